// File: doc/BRIEF.md
# UART Loopback and Modem Line Router

This block sits between the pins of a UART that also has an infrared transmitter and the serial core behind them. In normal operation it passes the serial input pins to the receivers, the transmitter outputs to the pins, and the four modem status pins to the internal modem status lines. When loopback is on, the receivers listen to their own transmitters and the external inputs are cut off. The transmit pins are parked at their idle levels unless software asks to keep them running. The internal modem status lines are fed from the modem control bits. The way those bits are crossed depends on whether extended mode is selected.

The block holds a small extended control register and the low five modem control bits. The loopback enable is a single storage bit that either register can write. A test bit replaces the DTR pin level with the baud clock. The block also keeps change flags for the routed modem status lines, which a status read clears.

Top module: `lbk_router`

## Requirements
- R1: After reset, `ctl_rdata` and `mcr_rdata` read 0x00 and all four change flags are 0.
- R2: With loopback on, `uart_rx_int` equals `uart_tx_int` and `ir_rx_int` equals `ir_tx_int`, and the serial input pins have no effect. With loopback off, each follows its pin.
- R3: With loopback on and the keep-transmit bit (control bit 5) at 0, `uart_tx_pin` is 1 and `ir_tx_pin` is 0. Otherwise each pin follows its internal transmitter output.
- R4: With loopback off, `cts_s`, `dsr_s`, `ri_s` and `dcd_s` follow their pins, and the modem control bits have no effect on them.
- R5: With loopback on and extended mode (control bit 0) at 0, DSR takes DTR (modem control bit 0), CTS takes RTS (bit 1), RI takes OUT1 (bit 2) and DCD takes OUT2 (bit 3). The modem pins have no effect.
- R6: With loopback on and extended mode at 1, DTR drives both DSR and RI, and RTS drives both CTS and DCD.
- R7: The loopback enable is one stored bit, seen at bit 4 of both `ctl_rdata` and `mcr_rdata`. A write through either register sets or clears it. If both registers are written in the same cycle, the control register write wins.
- R8: With control bit 7 at 1, `dtr_pin` equals `baud_clk`. Otherwise it equals modem control bit 0. `rts_pin` always equals modem control bit 1.
- R9: A change of routed `cts_s`, `dsr_s` or `dcd_s` between two clock edges sets its flag at the second edge. `ri_trail` sets only when `ri_s` falls from 1 to 0. No flag sets at the first edge after reset.
- R10: A cycle with `stat_rd` high clears the change flags at its edge. A flag whose event falls in that same cycle stays set.
- R11: The control register stores all eight written bits, reserved bit 6 included. The modem control register stores bits 4:0 and reads bits 7:5 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe, extended control register |
| ctl_wdata | input | 8 | Write data, extended control register |
| mcr_we | input | 1 | Write strobe, modem control register |
| mcr_wdata | input | 8 | Write data, modem control register |
| stat_rd | input | 1 | Modem status read, clears change flags |
| uart_rx_pin | input | 1 | External UART serial input |
| ir_rx_pin | input | 1 | External infrared serial input |
| uart_tx_int | input | 1 | Internal UART transmitter output |
| ir_tx_int | input | 1 | Internal infrared transmitter output |
| dsr_pin | input | 1 | DSR input pin |
| cts_pin | input | 1 | CTS input pin |
| ri_pin | input | 1 | RI input pin |
| dcd_pin | input | 1 | DCD input pin |
| baud_clk | input | 1 | Baud generator output |
| ctl_rdata | output | 8 | Extended control register contents |
| mcr_rdata | output | 8 | Modem control register contents |
| uart_rx_int | output | 1 | Internal UART receiver input |
| ir_rx_int | output | 1 | Internal infrared receiver input |
| uart_tx_pin | output | 1 | UART transmit pin |
| ir_tx_pin | output | 1 | Infrared transmit pin |
| dtr_pin | output | 1 | DTR output pin |
| rts_pin | output | 1 | RTS output pin |
| cts_s | output | 1 | Routed internal CTS |
| dsr_s | output | 1 | Routed internal DSR |
| ri_s | output | 1 | Routed internal RI |
| dcd_s | output | 1 | Routed internal DCD |
| cts_chg | output | 1 | CTS change flag |
| dsr_chg | output | 1 | DSR change flag |
| ri_trail | output | 1 | RI falling-edge flag |
| dcd_chg | output | 1 | DCD change flag |

## Verification
On every cycle, the assertions check several properties. Receivers take their own transmitters in loopback. Transmit pins are parked whenever loopback is on without the keep bit. In extended loopback the DSR/RI and CTS/DCD pairs stay equal. A write through either register lands in the shared loop bit. Each detected modem event is followed by its flag, and a read with no coincident event leaves the flag clear. The bench scenarios are needed for the remaining behaviour: the exact non-extended cross-mapping, the write priority between the two registers, the readback of reserved and unused bits, baud clock substitution on DTR, flag suppression right after reset, and the RI rising edge that sets nothing.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int REG_W  = 8;
  localparam int MLINES = 4;
  localparam int MCR_LO = 4;

  // control register field positions
  localparam int XM_BIT  = 0;  // extended mode
  localparam int LB_BIT  = 4;  // shared loopback bit
  localparam int TXK_BIT = 5;  // keep transmit pins live in loopback
  localparam int BT_BIT  = 7;  // baud clock onto DTR

  // modem control low bits
  localparam int DTR_BIT  = 0;
  localparam int RTS_BIT  = 1;
  localparam int OUT1_BIT = 2;
  localparam int OUT2_BIT = 3;

  // routed modem line order
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  // Choose the source of each internal modem status line.
  function automatic logic [MLINES-1:0] map_modem(
    input logic              loop,
    input logic              ext,
    input logic [MLINES-1:0] pins,
    input logic [MCR_LO-1:0] ctl
  );
    logic [MLINES-1:0] r;
    if (!loop) begin
      r = pins;
    end else if (ext) begin
      r[IDX_DSR] = ctl[DTR_BIT];
      r[IDX_RI]  = ctl[DTR_BIT];
      r[IDX_CTS] = ctl[RTS_BIT];
      r[IDX_DCD] = ctl[RTS_BIT];
    end else begin
      r[IDX_DSR] = ctl[DTR_BIT];
      r[IDX_CTS] = ctl[RTS_BIT];
      r[IDX_RI]  = ctl[OUT1_BIT];
      r[IDX_DCD] = ctl[OUT2_BIT];
    end
    return r;
  endfunction

  // Event detector: any change, or only a 1->0 transition.
  function automatic logic delta_hit(
    input logic prev,
    input logic cur,
    input logic fall_only
  );
    return fall_only ? (prev & ~cur) : (prev ^ cur);
  endfunction
endpackage

// File: rtl/lbk_ctl_regs.sv
module lbk_ctl_regs
  import lbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             mcr_we,
  input  logic [REG_W-1:0] mcr_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  output logic [REG_W-1:0] mcr_rdata,
  output logic             loop_q,
  output logic [MCR_LO-1:0] mcr_lo_q
);
  localparam int HI_W = REG_W - LB_BIT - 1;

  logic [LB_BIT-1:0] ctl_lo_q;
  logic [HI_W-1:0]   ctl_hi_q;
  logic              loop_wr;
  logic              loop_nxt;

  // control register write has priority over modem control
  assign loop_wr  = ctl_we | mcr_we;
  assign loop_nxt = ctl_we ? ctl_wdata[LB_BIT] : mcr_wdata[LB_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lo_q <= '0;
      ctl_hi_q <= '0;
      loop_q   <= 1'b0;
      mcr_lo_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_lo_q <= ctl_wdata[LB_BIT-1:0];
        ctl_hi_q <= ctl_wdata[REG_W-1:LB_BIT+1];
      end
      if (mcr_we) mcr_lo_q <= mcr_wdata[MCR_LO-1:0];
      if (loop_wr) loop_q <= loop_nxt;
    end
  end

  assign ctl_rdata = {ctl_hi_q, loop_q, ctl_lo_q};
  assign mcr_rdata = {{(REG_W-LB_BIT-1){1'b0}}, loop_q, mcr_lo_q};

  // R7
  ctl_loop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (loop_q == $past(ctl_wdata[LB_BIT])));
  // R7
  mcr_loop_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_we && !ctl_we) |=> (loop_q == $past(mcr_wdata[LB_BIT])));
  // R7
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !mcr_we) |=> $stable(loop_q));
endmodule

// File: rtl/lbk_serial_route.sv
module lbk_serial_route
  import lbk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loop,
  input  logic tx_keep,
  input  logic uart_rx_pin,
  input  logic ir_rx_pin,
  input  logic uart_tx_int,
  input  logic ir_tx_int,
  output logic uart_rx_int,
  output logic ir_rx_int,
  output logic uart_tx_pin,
  output logic ir_tx_pin
);
  logic park;

  assign park        = loop & ~tx_keep;
  assign uart_rx_int = loop ? uart_tx_int : uart_rx_pin;
  assign ir_rx_int   = loop ? ir_tx_int   : ir_rx_pin;
  // idle levels: UART line high, infrared emitter dark
  assign uart_tx_pin = park ? 1'b1 : uart_tx_int;
  assign ir_tx_pin   = park ? 1'b0 : ir_tx_int;

  // R2
  rx_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> (uart_rx_int == uart_tx_int) && (ir_rx_int == ir_tx_int));
  // R3
  tx_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop && !tx_keep) |-> (uart_tx_pin && !ir_tx_pin));
  // R3
  tx_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop || tx_keep) |-> (uart_tx_pin == uart_tx_int) && (ir_tx_pin == ir_tx_int));
endmodule

// File: rtl/lbk_modem_route.sv
module lbk_modem_route
  import lbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop,
  input  logic              ext,
  input  logic [MLINES-1:0] pins,
  input  logic [MCR_LO-1:0] mcr_lo,
  output logic [MLINES-1:0] routed
);
  assign routed = map_modem(loop, ext, pins, mcr_lo);

  // R6
  ext_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop && ext) |-> (routed[IDX_RI] == routed[IDX_DSR]) &&
                      (routed[IDX_DCD] == routed[IDX_CTS]));
  // R4
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop |-> (routed == pins));
  // R5
  dsr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> (routed[IDX_DSR] == mcr_lo[DTR_BIT]) && (routed[IDX_CTS] == mcr_lo[RTS_BIT]));
endmodule

// File: rtl/lbk_delta_trk.sv
module lbk_delta_trk
  import lbk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MLINES-1:0] cur,
  input  logic              clr,
  output logic [MLINES-1:0] flag
);
  logic              primed;
  logic [MLINES-1:0] prev;
  logic [MLINES-1:0] evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      prev   <= '0;
    end else begin
      primed <= 1'b1;
      prev   <= cur;
    end
  end

  for (genvar i = 0; i < MLINES; i++) begin : g_line
    localparam bit FALL_ONLY = (i == IDX_RI);
    assign evt[i] = primed & delta_hit(prev[i], cur[i], FALL_ONLY);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b1;
      else if (clr)    flag[i] <= 1'b0;
    end

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);
    // R10
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !flag[i]);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !evt[i]) |=> $stable(flag[i]));
  end

  // R9
  ri_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[IDX_RI]) |-> $past(prev[IDX_RI] && !cur[IDX_RI]));
endmodule

// File: rtl/lbk_router.sv
module lbk_router
  import lbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       mcr_we,
  input  logic [7:0] mcr_wdata,
  input  logic       stat_rd,
  input  logic       uart_rx_pin,
  input  logic       ir_rx_pin,
  input  logic       uart_tx_int,
  input  logic       ir_tx_int,
  input  logic       dsr_pin,
  input  logic       cts_pin,
  input  logic       ri_pin,
  input  logic       dcd_pin,
  input  logic       baud_clk,
  output logic [7:0] ctl_rdata,
  output logic [7:0] mcr_rdata,
  output logic       uart_rx_int,
  output logic       ir_rx_int,
  output logic       uart_tx_pin,
  output logic       ir_tx_pin,
  output logic       dtr_pin,
  output logic       rts_pin,
  output logic       cts_s,
  output logic       dsr_s,
  output logic       ri_s,
  output logic       dcd_s,
  output logic       cts_chg,
  output logic       dsr_chg,
  output logic       ri_trail,
  output logic       dcd_chg
);
  logic              loop_q;
  logic [MCR_LO-1:0] mcr_lo_q;
  logic [MLINES-1:0] pins;
  logic [MLINES-1:0] routed;
  logic [MLINES-1:0] flags;

  lbk_ctl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .mcr_we    (mcr_we),
    .mcr_wdata (mcr_wdata),
    .ctl_rdata (ctl_rdata),
    .mcr_rdata (mcr_rdata),
    .loop_q    (loop_q),
    .mcr_lo_q  (mcr_lo_q)
  );

  lbk_serial_route u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop        (loop_q),
    .tx_keep     (ctl_rdata[TXK_BIT]),
    .uart_rx_pin (uart_rx_pin),
    .ir_rx_pin   (ir_rx_pin),
    .uart_tx_int (uart_tx_int),
    .ir_tx_int   (ir_tx_int),
    .uart_rx_int (uart_rx_int),
    .ir_rx_int   (ir_rx_int),
    .uart_tx_pin (uart_tx_pin),
    .ir_tx_pin   (ir_tx_pin)
  );

  assign pins[IDX_CTS] = cts_pin;
  assign pins[IDX_DSR] = dsr_pin;
  assign pins[IDX_RI]  = ri_pin;
  assign pins[IDX_DCD] = dcd_pin;

  lbk_modem_route u_mdm (
    .clk    (clk),
    .rst_n  (rst_n),
    .loop   (loop_q),
    .ext    (ctl_rdata[XM_BIT]),
    .pins   (pins),
    .mcr_lo (mcr_lo_q),
    .routed (routed)
  );

  lbk_delta_trk u_dlt (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (routed),
    .clr   (stat_rd),
    .flag  (flags)
  );

  assign cts_s    = routed[IDX_CTS];
  assign dsr_s    = routed[IDX_DSR];
  assign ri_s     = routed[IDX_RI];
  assign dcd_s    = routed[IDX_DCD];
  assign cts_chg  = flags[IDX_CTS];
  assign dsr_chg  = flags[IDX_DSR];
  assign ri_trail = flags[IDX_RI];
  assign dcd_chg  = flags[IDX_DCD];

  assign dtr_pin = ctl_rdata[BT_BIT] ? baud_clk : mcr_lo_q[DTR_BIT];
  assign rts_pin = mcr_lo_q[RTS_BIT];

  // R8
  baud_dtr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[BT_BIT] |-> (dtr_pin == baud_clk));
  // R7
  loop_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[LB_BIT] == mcr_rdata[LB_BIT]);
endmodule

// File: tb/lbk_router_test.sv
`timescale 1ns/1ps
module lbk_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0, mcr_we = 1'b0, stat_rd = 1'b0;
  logic [7:0] ctl_wdata = 8'h00, mcr_wdata = 8'h00;
  logic       uart_rx_pin = 1'b0, ir_rx_pin = 1'b1;
  logic       uart_tx_int = 1'b0, ir_tx_int = 1'b0;
  logic       dsr_pin = 1'b1, cts_pin = 1'b0, ri_pin = 1'b0, dcd_pin = 1'b0;
  logic       baud_clk = 1'b0;
  logic [7:0] ctl_rdata, mcr_rdata;
  logic       uart_rx_int, ir_rx_int, uart_tx_pin, ir_tx_pin, dtr_pin, rts_pin;
  logic       cts_s, dsr_s, ri_s, dcd_s, cts_chg, dsr_chg, ri_trail, dcd_chg;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lbk_router uut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic wr_mcr(input logic [7:0] d);
    mcr_we = 1'b1; mcr_wdata = d;
    tick();
    mcr_we = 1'b0;
  endtask

  task automatic clear_flags();
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
  endtask

  function automatic logic [7:0] modem4();
    return {4'h0, cts_s, dsr_s, ri_s, dcd_s};
  endfunction

  function automatic logic [7:0] flags4();
    return {4'h0, cts_chg, dsr_chg, ri_trail, dcd_chg};
  endfunction

  task automatic t_reset();
    repeat (2) tick();
    check("R1 ctl reset", ctl_rdata, 8'h00);
    check("R1 mcr reset", mcr_rdata, 8'h00);
    check("R1/R9 flags after reset with dsr high", flags4(), 8'h00);
    check("R4 dsr passthrough", {7'b0, dsr_s}, 8'h01);
  endtask

  task automatic t_regs();
    wr_ctl(8'hC1);
    check("R11 ctl all bits", ctl_rdata, 8'hC1);
    wr_mcr(8'hFF);
    check("R11 mcr upper zero", mcr_rdata, 8'h1F);
    check("R7 loop via mcr seen in ctl", ctl_rdata, 8'hD1);
    ctl_we = 1'b1; ctl_wdata = 8'h00; mcr_we = 1'b1; mcr_wdata = 8'h10;
    tick();
    ctl_we = 1'b0; mcr_we = 1'b0;
    check("R7 simultaneous ctl wins (ctl)", ctl_rdata, 8'h00);
    check("R7 simultaneous ctl wins (mcr)", mcr_rdata, 8'h00);
  endtask

  task automatic t_serial();
    uart_rx_pin = 1'b1; ir_rx_pin = 1'b0; uart_tx_int = 1'b0; ir_tx_int = 1'b1;
    #1;
    check("R2 rx from pins", {6'b0, uart_rx_int, ir_rx_int}, 8'h02);
    check("R3 tx follows", {6'b0, uart_tx_pin, ir_tx_pin}, 8'h01);
    wr_ctl(8'h10);
    check("R2 rx loopback", {6'b0, uart_rx_int, ir_rx_int}, 8'h01);
    check("R3 tx parked", {6'b0, uart_tx_pin, ir_tx_pin}, 8'h02);
    wr_ctl(8'h30);
    check("R3 tx kept", {6'b0, uart_tx_pin, ir_tx_pin}, 8'h01);
    uart_tx_int = 1'b1; ir_tx_int = 1'b0; uart_rx_pin = 1'b0; ir_rx_pin = 1'b1;
    #1;
    check("R3 tx kept toggled", {6'b0, uart_tx_pin, ir_tx_pin}, 8'h02);
    check("R2 rx loopback toggled", {6'b0, uart_rx_int, ir_rx_int}, 8'h02);
  endtask

  task automatic t_modem_normal();
    wr_ctl(8'h00);
    cts_pin = 1'b1; dsr_pin = 1'b0; ri_pin = 1'b1; dcd_pin = 1'b0;
    #1;
    check("R4 pins pass", modem4(), 8'h0A);
    wr_mcr(8'h0F);
    check("R4 mcr ignored", modem4(), 8'h0A);
  endtask

  task automatic t_loop_nonext();
    wr_mcr(8'h15);
    check("R5 dtr/out1", modem4(), 8'h06);
    wr_mcr(8'h1A);
    check("R5 rts/out2", modem4(), 8'h09);
    cts_pin = 1'b0; dcd_pin = 1'b1;
    #1;
    check("R5 pins ignored", modem4(), 8'h09);
  endtask

  task automatic t_loop_ext();
    wr_ctl(8'h11);
    check("R6 rts drives cts+dcd", modem4(), 8'h09);
    wr_mcr(8'h15);
    check("R6 dtr drives dsr+ri, out1 ignored", modem4(), 8'h06);
  endtask

  task automatic t_baud();
    wr_ctl(8'h80);
    wr_mcr(8'h01);
    baud_clk = 1'b0; #1;
    check("R8 baud low on dtr", {7'b0, dtr_pin}, 8'h00);
    baud_clk = 1'b1; #1;
    check("R8 baud high on dtr", {7'b0, dtr_pin}, 8'h01);
    wr_ctl(8'h00);
    baud_clk = 1'b0; #1;
    check("R8 dtr from mcr", {6'b0, dtr_pin, rts_pin}, 8'h02);
  endtask

  task automatic t_delta();
    wr_mcr(8'h00);
    cts_pin = 1'b0; dsr_pin = 1'b0; ri_pin = 1'b0; dcd_pin = 1'b0;
    tick();
    clear_flags();
    check("R10 cleared", flags4(), 8'h00);
    cts_pin = 1'b1;
    tick();
    check("R9 cts change", flags4(), 8'h08);
    ri_pin = 1'b1;
    tick();
    check("R9 ri rise no flag", flags4(), 8'h08);
    ri_pin = 1'b0;
    tick();
    check("R9 ri fall flag", flags4(), 8'h0A);
    dcd_pin = 1'b1;
    tick();
    dcd_pin = 1'b0;
    tick();
    check("R9 dcd change", flags4(), 8'h0B);
  endtask

  task automatic t_clear();
    clear_flags();
    check("R10 read clears", flags4(), 8'h00);
    stat_rd = 1'b1; dsr_pin = 1'b1;
    tick();
    stat_rd = 1'b0;
    check("R10 event beats clear", flags4(), 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_serial();
    t_modem_normal();
    t_loop_nonext();
    t_loop_ext();
    t_baud();
    t_delta();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule